// File: doc/BRIEF.md
# Command Slot Issue Sequencer

This block sits between a host register interface and the execution unit of a multi-slot command engine. It tells the execution unit which slot holds a command that is ready to run. The host can submit a command in two ways. With an activation write, it gives a slot number and the 64-bit address of a 64-byte command descriptor in host memory. The block queues that fetch, hands it to an external fetch engine when the engine is free, and reports the slot as ready once the engine signals that the fetch is done. With a direct write, the host has already placed the descriptor in slot memory and only gives the slot number. That slot is then reported as ready without any fetch.

Both paths feed one ready-slot stream. Each output beat carries a source flag that tells the two paths apart. Fetches are served one at a time, strictly in the order the activation writes arrived. The host may keep writing activations while earlier fetches are still waiting. A queue-clear input discards all outstanding work.

Top module: `cmd_issue_seq`

## Requirements
- R1: While reset is held and right after it is released, `fetch_req_o`, `rdy_valid_o` and `dup_err_o` are low.
- R2: An activation write (`wr_kind_i`=0) for a free slot, while no fetch is active and nothing is queued, raises `fetch_req_o` after the second rising edge that follows the write edge. At that point `fetch_slot_o` shows the written slot and `fetch_addr_o` shows the written address.
- R3: Once raised, `fetch_req_o` stays high and the slot and address stay stable until `fetch_done_i` is sampled high.
- R4: When `fetch_done_i` is sampled high during a fetch, `rdy_valid_o` is high for exactly one cycle after that edge. In that cycle `rdy_slot_o` shows the fetched slot and `rdy_src_o`=0. `fetch_req_o` drops at the same edge.
- R5: Queued fetches are issued one at a time, in the order their activation writes arrived. The queue holds one entry for each of the NUM_SLOTS slots.
- R6: A slot counts as pending from its accepted activation write until its completion. An activation write to a pending slot is ignored and sets `dup_err_o`, which stays set until reset. Once the slot has completed, a new activation write to it is accepted.
- R7: A direct write (`wr_kind_i`=1) makes `rdy_valid_o` high after the second rising edge that follows the write edge, with `rdy_src_o`=1. Direct writes are reported in the order they were written, one per cycle.
- R8: When a fetch completion and a waiting direct entry would go out in the same cycle, the completion goes first and the direct entry follows one cycle later.
- R9: A write whose slot number is NUM_SLOTS or larger has no effect on either path and does not set `dup_err_o`.
- R10: A cycle with `clear_i` high does the following:
  - empties the fetch queue and the direct queue;
  - drops the active fetch, so `fetch_req_o` is low after that edge and a later `fetch_done_i` reports nothing;
  - marks every slot as free;
  - ignores any write in the same cycle;
  - leaves `dup_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Discard all queued and active work |
| wr_valid_i | input | 1 | Host write strobe |
| wr_kind_i | input | 1 | 0 = activation write, 1 = direct write |
| wr_slot_i | input | SLOT_W | Slot number of the write |
| wr_addr_i | input | ADDR_W | Descriptor address (activation writes only) |
| fetch_req_o | output | 1 | Fetch request, held until done |
| fetch_slot_o | output | SLOT_W | Slot to fill |
| fetch_addr_o | output | ADDR_W | Descriptor address to fetch |
| fetch_done_i | input | 1 | Fetch engine has finished the current fetch |
| rdy_valid_o | output | 1 | One-cycle ready-slot beat |
| rdy_slot_o | output | SLOT_W | Slot that is ready to execute |
| rdy_src_o | output | 1 | 0 = reached by fetch, 1 = direct write |
| dup_err_o | output | 1 | Sticky flag for an activation write to a pending slot |

## Verification
The bench builds the block with NUM_SLOTS=31, ADDR_W=64 and DIR_DEPTH=4. With 31 slots, the fetch queue can be filled to its full depth with one activation for every slot, and each is then drained in a permuted order. The 5-bit slot field can also carry the value 31, so an out-of-range slot number can be written directly. The 4-entry direct queue is deep enough to hold a direct entry back while a fetch completion takes the output. This makes the collision ordering observable cycle by cycle.

// File: rtl/cis_pkg.sv
package cis_pkg;

    typedef enum logic {
        KIND_ACTIVATE = 1'b0,
        KIND_DIRECT   = 1'b1
    } wr_kind_e;

    typedef enum logic {
        SRC_FETCHED = 1'b0,
        SRC_DIRECT  = 1'b1
    } rdy_src_e;

endpackage

// File: rtl/cis_fifo.sv
module cis_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    logic full;
    logic do_push;
    logic do_pop;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CNT_W'(DEPTH));
        do_push = push_i && !full;
        do_pop  = pop_i && (st_q.cnt != '0);
        if (clear_i) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data_i;
                st_d.wr           = ptr_next(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign empty_o = (st_q.cnt == '0);

endmodule

// File: rtl/cis_fetch_ctl.sv
module cis_fetch_ctl #(
    parameter int NUM_SLOTS = 31,
    parameter int SLOT_W    = 5,
    parameter int ADDR_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              act_valid_i,
    input  logic [SLOT_W-1:0] act_slot_i,
    input  logic              q_empty_i,
    input  logic [SLOT_W-1:0] q_head_slot_i,
    input  logic [ADDR_W-1:0] q_head_addr_i,
    input  logic              fetch_done_i,
    output logic              act_push_o,
    output logic              q_pop_o,
    output logic              fetch_req_o,
    output logic [SLOT_W-1:0] fetch_slot_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              cmpl_valid_o,
    output logic [SLOT_W-1:0] cmpl_slot_o,
    output logic              dup_err_o
);
    typedef struct packed {
        logic                 busy;
        logic [SLOT_W-1:0]    slot;
        logic [ADDR_W-1:0]    addr;
        logic [NUM_SLOTS-1:0] pending;
        logic                 err;
    } fctl_st_t;

    fctl_st_t st_d, st_q;

    logic cmpl;
    logic slot_free;
    logic dup;

    always_comb begin
        st_d      = st_q;
        cmpl      = st_q.busy && fetch_done_i && !clear_i;
        slot_free = !st_q.pending[act_slot_i] || (cmpl && (st_q.slot == act_slot_i));
        act_push_o = act_valid_i && !clear_i && slot_free;
        dup        = act_valid_i && !clear_i && !slot_free;
        q_pop_o    = !st_q.busy && !q_empty_i && !clear_i;

        if (clear_i) begin
            st_d.busy    = 1'b0;
            st_d.pending = '0;
        end else begin
            if (cmpl) begin
                st_d.busy               = 1'b0;
                st_d.pending[st_q.slot] = 1'b0;
            end
            if (q_pop_o) begin
                st_d.busy = 1'b1;
                st_d.slot = q_head_slot_i;
                st_d.addr = q_head_addr_i;
            end
            if (act_push_o) begin
                st_d.pending[act_slot_i] = 1'b1;
            end
            if (dup) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_req_o  = st_q.busy;
    assign fetch_slot_o = st_q.slot;
    assign fetch_addr_o = st_q.addr;
    assign cmpl_valid_o = cmpl;
    assign cmpl_slot_o  = st_q.slot;
    assign dup_err_o    = st_q.err;

endmodule

// File: rtl/cis_ready_mux.sv
module cis_ready_mux
    import cis_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cmpl_valid_i,
    input  logic [SLOT_W-1:0] cmpl_slot_i,
    input  logic              dir_empty_i,
    input  logic [SLOT_W-1:0] dir_head_i,
    output logic              dir_pop_o,
    output logic              rdy_valid_o,
    output logic [SLOT_W-1:0] rdy_slot_o,
    output logic              rdy_src_o
);
    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
        rdy_src_e          src;
    } rmux_st_t;

    rmux_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        dir_pop_o  = 1'b0;
        if (!clear_i) begin
            if (cmpl_valid_i) begin
                st_d.valid = 1'b1;
                st_d.slot  = cmpl_slot_i;
                st_d.src   = SRC_FETCHED;
            end else if (!dir_empty_i) begin
                dir_pop_o  = 1'b1;
                st_d.valid = 1'b1;
                st_d.slot  = dir_head_i;
                st_d.src   = SRC_DIRECT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{valid: 1'b0, slot: '0, src: SRC_FETCHED};
        else        st_q <= st_d;
    end

    assign rdy_valid_o = st_q.valid;
    assign rdy_slot_o  = st_q.slot;
    assign rdy_src_o   = st_q.src;

endmodule

// File: rtl/cmd_issue_seq.sv
module cmd_issue_seq
    import cis_pkg::*;
#(
    parameter int  NUM_SLOTS = 31,
    parameter int  ADDR_W    = 64,
    parameter int  DIR_DEPTH = 4,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_valid_i,
    input  logic              wr_kind_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              fetch_req_o,
    output logic [SLOT_W-1:0] fetch_slot_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_done_i,
    output logic              rdy_valid_o,
    output logic [SLOT_W-1:0] rdy_slot_o,
    output logic              rdy_src_o,
    output logic              dup_err_o
);
    localparam int FQ_W = SLOT_W + ADDR_W;

    logic              in_range;
    logic              act_valid;
    logic              dir_push;
    logic              act_push;
    logic              fq_pop;
    logic              fq_empty;
    logic [FQ_W-1:0]   fq_head;
    logic              cmpl_valid;
    logic [SLOT_W-1:0] cmpl_slot;
    logic              dq_pop;
    logic              dq_empty;
    logic [SLOT_W-1:0] dq_head;

    assign in_range  = {1'b0, wr_slot_i} < (SLOT_W + 1)'(NUM_SLOTS);
    assign act_valid = wr_valid_i && in_range && (wr_kind_i == KIND_ACTIVATE);
    assign dir_push  = wr_valid_i && in_range && (wr_kind_i == KIND_DIRECT) && !clear_i;

    cis_fifo #(
        .WIDTH (FQ_W),
        .DEPTH (NUM_SLOTS)
    ) u_fetch_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .push_i      (act_push),
        .push_data_i ({wr_slot_i, wr_addr_i}),
        .pop_i       (fq_pop),
        .head_o      (fq_head),
        .empty_o     (fq_empty)
    );

    cis_fetch_ctl #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .ADDR_W    (ADDR_W)
    ) u_fetch_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .act_valid_i   (act_valid),
        .act_slot_i    (wr_slot_i),
        .q_empty_i     (fq_empty),
        .q_head_slot_i (fq_head[FQ_W-1:ADDR_W]),
        .q_head_addr_i (fq_head[ADDR_W-1:0]),
        .fetch_done_i  (fetch_done_i),
        .act_push_o    (act_push),
        .q_pop_o       (fq_pop),
        .fetch_req_o   (fetch_req_o),
        .fetch_slot_o  (fetch_slot_o),
        .fetch_addr_o  (fetch_addr_o),
        .cmpl_valid_o  (cmpl_valid),
        .cmpl_slot_o   (cmpl_slot),
        .dup_err_o     (dup_err_o)
    );

    cis_fifo #(
        .WIDTH (SLOT_W),
        .DEPTH (DIR_DEPTH)
    ) u_dir_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .push_i      (dir_push),
        .push_data_i (wr_slot_i),
        .pop_i       (dq_pop),
        .head_o      (dq_head),
        .empty_o     (dq_empty)
    );

    cis_ready_mux #(
        .SLOT_W (SLOT_W)
    ) u_rdy_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .cmpl_valid_i (cmpl_valid),
        .cmpl_slot_i  (cmpl_slot),
        .dir_empty_i  (dq_empty),
        .dir_head_i   (dq_head),
        .dir_pop_o    (dq_pop),
        .rdy_valid_o  (rdy_valid_o),
        .rdy_slot_o   (rdy_slot_o),
        .rdy_src_o    (rdy_src_o)
    );

endmodule

// File: rtl/cis_checker.sv
module cis_checker #(
    parameter int NUM_SLOTS = 31,
    parameter int ADDR_W    = 64,
    parameter int SLOT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              fetch_req_o,
    input logic [SLOT_W-1:0] fetch_slot_o,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              fetch_done_i,
    input logic              rdy_valid_o,
    input logic [SLOT_W-1:0] rdy_slot_o,
    input logic              rdy_src_o,
    input logic              dup_err_o
);

    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_done_i && !clear_i) |=>
        (fetch_req_o && $stable(fetch_slot_o) && $stable(fetch_addr_o))); // R3

    AST_DONE_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_done_i && !clear_i) |=>
        (rdy_valid_o && !rdy_src_o && (rdy_slot_o == $past(fetch_slot_o)))); // R4

    AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_done_i) |=> !fetch_req_o); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err_o |=> dup_err_o); // R6

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid_o |-> ({1'b0, rdy_slot_o} < (SLOT_W + 1)'(NUM_SLOTS))); // R9

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!fetch_req_o && !rdy_valid_o)); // R10

endmodule

bind cmd_issue_seq cis_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .SLOT_W    (SLOT_W)
) u_cis_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_slot_o (fetch_slot_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_done_i (fetch_done_i),
    .rdy_valid_o  (rdy_valid_o),
    .rdy_slot_o   (rdy_slot_o),
    .rdy_src_o    (rdy_src_o),
    .dup_err_o    (dup_err_o)
);

// File: tb/tb_cmd_issue_seq.sv
module tb_cmd_issue_seq;
    localparam int NS = 31;
    localparam int AW = 64;
    localparam int DD = 4;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic          wr_valid_i = 1'b0;
    logic          wr_kind_i = 1'b0;
    logic [SW-1:0] wr_slot_i = '0;
    logic [AW-1:0] wr_addr_i = '0;
    logic          fetch_done_i = 1'b0;
    logic          fetch_req_o;
    logic [SW-1:0] fetch_slot_o;
    logic [AW-1:0] fetch_addr_o;
    logic          rdy_valid_o;
    logic [SW-1:0] rdy_slot_o;
    logic          rdy_src_o;
    logic          dup_err_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cmd_issue_seq #(
        .NUM_SLOTS (NS),
        .ADDR_W    (AW),
        .DIR_DEPTH (DD)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .wr_valid_i   (wr_valid_i),
        .wr_kind_i    (wr_kind_i),
        .wr_slot_i    (wr_slot_i),
        .wr_addr_i    (wr_addr_i),
        .fetch_req_o  (fetch_req_o),
        .fetch_slot_o (fetch_slot_o),
        .fetch_addr_o (fetch_addr_o),
        .fetch_done_i (fetch_done_i),
        .rdy_valid_o  (rdy_valid_o),
        .rdy_slot_o   (rdy_slot_o),
        .rdy_src_o    (rdy_src_o),
        .dup_err_o    (dup_err_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit kind, input int slot, input logic [AW-1:0] addr);
        wr_valid_i = 1'b1;
        wr_kind_i  = kind;
        wr_slot_i  = SW'(slot);
        wr_addr_i  = addr;
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic done_pulse();
        fetch_done_i = 1'b1;
        @(negedge clk);
        fetch_done_i = 1'b0;
    endtask

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (fetch_req_o) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 req in reset", 64'(fetch_req_o), 0);
        chk("R1 rdy in reset", 64'(rdy_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req after reset", 64'(fetch_req_o), 0);
        chk("R1 rdy after reset", 64'(rdy_valid_o), 0);
        chk("R1 err after reset", 64'(dup_err_o), 0);
    endtask

    task automatic t_single();
        wr(0, 5, 64'h0000_1234_5678_9AC0);
        chk("R2 req not yet", 64'(fetch_req_o), 0);
        @(negedge clk);
        chk("R2 req raised", 64'(fetch_req_o), 1);
        chk("R2 slot", 64'(fetch_slot_o), 5);
        chk("R2 addr", fetch_addr_o, 64'h0000_1234_5678_9AC0);
        repeat (3) @(negedge clk);
        chk("R3 held", {63'(fetch_slot_o), fetch_req_o}, {63'd5, 1'b1});
        chk("R3 addr held", fetch_addr_o, 64'h0000_1234_5678_9AC0);
        done_pulse();
        chk("R4 rdy beat", {62'(rdy_slot_o), rdy_src_o, rdy_valid_o}, {62'd5, 1'b0, 1'b1});
        chk("R4 req dropped", 64'(fetch_req_o), 0);
        @(negedge clk);
        chk("R4 one cycle", 64'(rdy_valid_o), 0);
    endtask

    task automatic t_range();
        logic err0;
        int   bad;
        err0 = dup_err_o;
        wr(0, 31, 64'hDEAD_0000);
        wr(1, 31, 0);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            if (fetch_req_o || rdy_valid_o) bad++;
            @(negedge clk);
        end
        chk("R9 out of range ignored", 64'(bad), 0);
        chk("R9 err unchanged", 64'(dup_err_o), 64'(err0));
    endtask

    task automatic t_direct();
        wr(1, 2, 0);
        chk("R7 not yet", 64'(rdy_valid_o), 0);
        @(negedge clk);
        chk("R7 direct beat", {62'(rdy_slot_o), rdy_src_o, rdy_valid_o}, {62'd2, 1'b1, 1'b1});
        wr_valid_i = 1'b1; wr_kind_i = 1'b1; wr_slot_i = 5'd9;
        @(negedge clk);
        wr_slot_i = 5'd4;
        @(negedge clk);
        wr_valid_i = 1'b0;
        chk("R7 order first", {62'(rdy_slot_o), rdy_src_o, rdy_valid_o}, {62'd9, 1'b1, 1'b1});
        @(negedge clk);
        chk("R7 order second", {62'(rdy_slot_o), rdy_src_o, rdy_valid_o}, {62'd4, 1'b1, 1'b1});
        @(negedge clk);
        chk("R7 drained", 64'(rdy_valid_o), 0);
    endtask

    task automatic t_collision();
        bit got;
        wr(0, 8, 64'h8000);
        wait_req(got);
        chk("R8 fetch up", 64'(got), 1);
        wr(1, 1, 0);
        done_pulse();
        chk("R8 completion first", {62'(rdy_slot_o), rdy_src_o, rdy_valid_o}, {62'd8, 1'b0, 1'b1});
        @(negedge clk);
        chk("R8 direct delayed", {62'(rdy_slot_o), rdy_src_o, rdy_valid_o}, {62'd1, 1'b1, 1'b1});
        @(negedge clk);
        chk("R8 idle after", 64'(rdy_valid_o), 0);
    endtask

    task automatic t_order();
        int slots [3] = '{3, 17, 30};
        bit got;
        chk("R6 err clear before dup", 64'(dup_err_o), 0);
        wr(0, 3, 64'h3300);
        wr(0, 17, 64'h1700);
        wr(0, 30, 64'h3000);
        wr(0, 17, 64'hFFFF);
        chk("R6 dup sets err", 64'(dup_err_o), 1);
        for (int i = 0; i < 3; i++) begin
            wait_req(got);
            chk("R5 fetch issued", 64'(got), 1);
            chk("R5 fetch slot order", 64'(fetch_slot_o), 64'(slots[i]));
            chk("R5 fetch addr order", fetch_addr_o, 64'(slots[i] == 3 ? 64'h3300 :
                                                         slots[i] == 17 ? 64'h1700 : 64'h3000));
            done_pulse();
        end
        repeat (4) @(negedge clk);
        chk("R6 dup not fetched", 64'(fetch_req_o), 0);
        chk("R6 err sticky", 64'(dup_err_o), 1);
        wr(0, 30, 64'h3040);
        @(negedge clk);
        chk("R6 slot reusable", {63'(fetch_slot_o), fetch_req_o}, {63'd30, 1'b1});
        done_pulse();
    endtask

    task automatic t_full();
        bit got;
        for (int i = 0; i < NS; i++) begin
            wr(0, (i * 7) % NS, 64'hA000_0000 + 64'((i * 7) % NS) * 64);
        end
        for (int i = 0; i < NS; i++) begin
            wait_req(got);
            chk("R5 full queue fetch", 64'(got), 1);
            chk("R5 full queue slot", 64'(fetch_slot_o), 64'((i * 7) % NS));
            chk("R5 full queue addr", fetch_addr_o, 64'hA000_0000 + 64'((i * 7) % NS) * 64);
            done_pulse();
            chk("R4 full queue report", {62'(rdy_slot_o), rdy_src_o, rdy_valid_o},
                {62'((i * 7) % NS), 1'b0, 1'b1});
        end
    endtask

    task automatic t_clear();
        bit got;
        int bad;
        wr(0, 10, 64'h1000);
        wr(0, 11, 64'h1100);
        wait_req(got);
        chk("R10 fetch up", 64'(fetch_slot_o), 10);
        clear_i = 1'b1;
        wr_valid_i = 1'b1; wr_kind_i = 1'b1; wr_slot_i = 5'd6;
        @(negedge clk);
        clear_i = 1'b0;
        wr_valid_i = 1'b0;
        chk("R10 req dropped", 64'(fetch_req_o), 0);
        done_pulse();
        chk("R10 late done ignored", 64'(rdy_valid_o), 0);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            if (fetch_req_o || rdy_valid_o) bad++;
            @(negedge clk);
        end
        chk("R10 queues emptied", 64'(bad), 0);
        chk("R10 err unchanged", 64'(dup_err_o), 1);
        wr(0, 10, 64'h1040);
        @(negedge clk);
        chk("R10 slot freed", {63'(fetch_slot_o), fetch_req_o}, {63'd10, 1'b1});
        done_pulse();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_range();
        t_direct();
        t_collision();
        t_order();
        t_full();
        t_clear();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule